// File: doc/BRIEF.md
# Quarter-Rate Quadrature Upconverter

This block moves a complex baseband stream onto a carrier at exactly one quarter of its sample clock, so each carrier period spans four samples. At that rate, the sampled cosine and sine of the carrier only take the values +1, 0 and -1. Mixing therefore needs no multiplier and no oscillator. Each output sample is built from a copy of I and a copy of Q, each passed, negated or zeroed according to a two-bit phase counter, and the two are added. The result is one real, signed output word per clock, ready for a downstream modulator or converter.

Two carrier sequence sets are available and are selected by `mode`. The block is fully pipelined with a single output register. It accepts a sample on every clock and has no ready output, so it never applies back-pressure. A source with nothing to send lowers `in_valid`, and that slot then contributes zero to the output, which gives zero-stuffing. The output is a continuous stream with no valid or ready of its own: a word appears on every clock.

Top module: `quad_upmix`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the phase counter to 0 and the output to 0.
- R2: The phase counter counts 0,1,2,3,0,... and advances on every clock out of reset, whether or not `in_valid` is high. The first sample presented in the clock that `rst` is released uses phase 0.
- R3: With `mode` = 0, the weight applied to I is +1, +1, -1, -1 for phases 0, 1, 2, 3.
- R4: With `mode` = 0, the weight applied to Q is -1, +1, +1, -1 for phases 0, 1, 2, 3.
- R5: With `mode` = 1, the weight applied to I is 0, +1, 0, -1 and the weight applied to Q is +1, 0, -1, 0 for phases 0, 1, 2, 3.
- R6: The output is the two's-complement sum of the weighted I and Q terms. The output is DATA_W+1 bits wide, so even two full-scale terms never overflow.
- R7: Negating the most negative input (-2^(DATA_W-1)) gives +2^(DATA_W-1)-1. It does not wrap back to the most negative value.
- R8: The output for a sample appears one clock after that sample is presented. Until that clock edge, the output keeps its previous value.
- R9: When `in_valid` is low, both terms are zero for that slot and the next output is 0, whatever `in_i`, `in_q` and `mode` are.
- R10: `mode` can change on any clock. The new mode applies to the sample presented in that same clock, and the change has no effect on the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the carrier frequency |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_i`/`in_q` carry a sample; low zero-stuffs the slot |
| in_i | input | DATA_W | In-phase sample, signed two's complement |
| in_q | input | DATA_W | Quadrature sample, signed two's complement |
| mode | input | 1 | Carrier sequence set: 0 = half-offset square patterns, 1 = zero-interleaved patterns |
| out_data | output | DATA_W+1 | Upconverted real sample, signed two's complement |

## Verification
The bench steps through all four phases in both modes with asymmetric I and Q values. If the weights were swapped between the I and Q paths, or shifted by one phase, the output would carry the wrong signs or values. Full-scale inputs are applied in combination: both terms at maximum, both at minimum, and negated minimum values. A design with an output only DATA_W bits wide would wrap these sums, and a design that negates without saturation would turn -2048 into -2048. Other tests reset the block in the middle of a stream, hold `in_valid` low over several phases, and change `mode` between samples. These catch a counter that stalls on idle slots, a counter that does not restart at phase 0, and idle slots that leak data into the output.

// File: rtl/upmix_pkg.sv
package upmix_pkg;

  // Number of samples per carrier period (sample clock = 4 x carrier).
  localparam int PHASES = 4;
  localparam int PH_W   = $clog2(PHASES);

  // Per-path weight: the carrier sample value at the current phase.
  typedef enum logic [1:0] {
    WT_ZERO = 2'd0,
    WT_POS  = 2'd1,
    WT_NEG  = 2'd2
  } weight_e;

  // Carrier sequence sets.
  typedef enum logic {
    SEQ_SQUARE = 1'b0,   // I: + + - -   Q: - + + -
    SEQ_SPARSE = 1'b1    // I: 0 + 0 -   Q: + 0 - 0
  } seq_e;

endpackage

// File: rtl/upmix_phase_ctr.sv
module upmix_phase_ctr #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase
);

  // Free-running modulo-2^PH_W counter; wraps naturally.
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + PH_W'(1);
  end

endmodule

// File: rtl/upmix_weight_lut.sv
module upmix_weight_lut
  import upmix_pkg::*;
(
  input  logic [PH_W-1:0] phase,
  input  logic            mode,
  output weight_e         wt_i,
  output weight_e         wt_q
);

  always_comb begin
    wt_i = WT_ZERO;
    wt_q = WT_ZERO;
    if (seq_e'(mode) == SEQ_SQUARE) begin
      unique case (phase)
        2'd0: begin wt_i = WT_POS; wt_q = WT_NEG; end
        2'd1: begin wt_i = WT_POS; wt_q = WT_POS; end
        2'd2: begin wt_i = WT_NEG; wt_q = WT_POS; end
        2'd3: begin wt_i = WT_NEG; wt_q = WT_NEG; end
        default: ;
      endcase
    end else begin
      unique case (phase)
        2'd0: begin wt_i = WT_ZERO; wt_q = WT_POS;  end
        2'd1: begin wt_i = WT_POS;  wt_q = WT_ZERO; end
        2'd2: begin wt_i = WT_ZERO; wt_q = WT_NEG;  end
        2'd3: begin wt_i = WT_NEG;  wt_q = WT_ZERO; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/upmix_term.sv
module upmix_term
  import upmix_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic                     en,
  input  weight_e                  wt,
  output logic signed [DATA_W-1:0] term
);

  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [DATA_W-1:0] neg_sat;

  // Saturating negation: the lone unrepresentable case clips to MAX_V.
  always_comb begin
    if (x == MIN_V) neg_sat = MAX_V;
    else            neg_sat = -x;
  end

  always_comb begin
    term = '0;
    if (en) begin
      unique case (wt)
        WT_POS:  term = x;
        WT_NEG:  term = neg_sat;
        default: term = '0;
      endcase
    end
  end

endmodule

// File: rtl/quad_upmix.sv
module quad_upmix
  import upmix_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic                     mode,
  output logic signed [DATA_W:0]   out_data
);

  localparam int OUT_W = DATA_W + 1;
  localparam int LANES = 2;   // lane 0 = I, lane 1 = Q

  logic [PH_W-1:0]          phase_q;
  weight_e                  lane_wt   [LANES];
  logic signed [DATA_W-1:0] lane_x    [LANES];
  logic signed [DATA_W-1:0] lane_term [LANES];
  logic signed [OUT_W-1:0]  sum_d;

  upmix_phase_ctr #(.PH_W(PH_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_q)
  );

  upmix_weight_lut u_lut (
    .phase (phase_q),
    .mode  (mode),
    .wt_i  (lane_wt[0]),
    .wt_q  (lane_wt[1])
  );

  assign lane_x[0] = in_i;
  assign lane_x[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    upmix_term #(.DATA_W(DATA_W)) u_term (
      .x    (lane_x[g]),
      .en   (in_valid),
      .wt   (lane_wt[g]),
      .term (lane_term[g])
    );
  end

  // One guard bit absorbs the carry of two full-scale terms.
  assign sum_d = {lane_term[0][DATA_W-1], lane_term[0]}
               + {lane_term[1][DATA_W-1], lane_term[1]};

  always_ff @(posedge clk) begin
    if (rst) out_data <= '0;
    else     out_data <= sum_d;
  end

endmodule

// File: rtl/quad_upmix_chk.sv
module quad_upmix_chk #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic                     mode,
  input logic signed [DATA_W:0]   out_data,
  input logic [1:0]               phase
);

  localparam int OUT_W = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0]  MAX_X = {2'b00, {(DATA_W-1){1'b1}}};

  function automatic logic signed [OUT_W-1:0] ext(input logic signed [DATA_W-1:0] v);
    return {v[DATA_W-1], v};
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_data == '0 && phase == '0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase == 2'($past(phase) + 2'd1));

  assert_square_p1_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && phase == 2'd1)
      |=> out_data == ext($past(in_i)) + ext($past(in_q)));

  assert_square_p3_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && phase == 2'd3 && in_i != MIN_V && in_q != MIN_V)
      |=> out_data == -ext($past(in_i)) - ext($past(in_q)));

  assert_sparse_p0_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode && phase == 2'd0) |=> out_data == ext($past(in_q)));

  assert_neg_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && phase == 2'd2 && in_i == MIN_V && in_q == '0)
      |=> out_data == MAX_X);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> out_data == '0);

endmodule

bind quad_upmix quad_upmix_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_i     (in_i),
  .in_q     (in_q),
  .mode     (mode),
  .out_data (out_data),
  .phase    (phase_q)
);

// File: tb/quad_upmix_test.sv
`timescale 1ns/1ps
module quad_upmix_test;

  localparam int W = 12;
  localparam int NV = 16;

  // Stimulus/expected table; vector k lands on phase k%4 after reset release.
  localparam int VI [NV] = '{100, 100, 100, 100, -5, -5, -5, -5,
                             500, 2047, -2048, -2048, -2048, -2048, 7, -2048};
  localparam int VQ [NV] = '{30, 30, 30, 30, 200, 200, 200, 200,
                             7, 2047, 0, -2048, 2047, -2048, -2048, 9};
  localparam bit VM [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam bit VV [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int VE [NV] = '{70, 130, -70, -130, 200, -5, -200, 5,
                             0, 4094, 2047, 4094, -4095, -4096, 2047, 2047};
  string vtag [NV] = '{"R3/R4", "R3/R4", "R3/R4", "R3/R4",
                       "R10/R5", "R5", "R5", "R5",
                       "R9", "R6", "R7", "R7/R6", "R6", "R6",
                       "R7/R5", "R7/R5"};

  logic                clk = 1'b0;
  logic                rst;
  logic                in_valid;
  logic signed [W-1:0] in_i;
  logic signed [W-1:0] in_q;
  logic                mode;
  logic signed [W:0]   out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  quad_upmix #(.DATA_W(W)) uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .mode     (mode),
    .out_data (out_data)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: out_data=%0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive(input bit v, input bit m, input int i, input int q);
    in_valid = v;
    mode     = m;
    in_i     = W'(i);
    in_q     = W'(q);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 1'b0, 321, -77);
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(out_data), 0);

    // Release reset together with the first vector: it takes phase 0.
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      drive(VV[k], VM[k], VI[k], VQ[k]);
      @(negedge clk);
      check(vtag[k], int'(out_data), VE[k]);
    end

    // Mid-stream reset, then restart at phase 0.
    rst = 1'b1;
    drive(1'b1, 1'b0, 999, 1);
    @(negedge clk);
    check("R1 mid-stream reset", int'(out_data), 0);
    rst = 1'b0;
    drive(1'b1, 1'b0, 10, 3);              // phase 0, mode 0: 10 - 3
    @(negedge clk);
    check("R2 restart at phase 0", int'(out_data), 7);

    // Idle slot at phase 1; counter must still advance.
    drive(1'b0, 1'b1, 300, 300);
    @(negedge clk);
    check("R9 idle slot zero", int'(out_data), 0);
    drive(1'b1, 1'b0, 50, 0);              // phase 2, mode 0: -50
    @(negedge clk);
    check("R2 phase advances over idle", int'(out_data), -50);
    drive(1'b1, 1'b1, -7, 1000);           // phase 3, mode 1: -(-7)
    @(negedge clk);
    check("R5 sparse phase 3", int'(out_data), 7);
    drive(1'b1, 1'b1, 0, -2048);           // phase 0, mode 1: +Q
    @(negedge clk);
    check("R5 sparse phase 0 min", int'(out_data), -2048);

    // Latency: new input must not show before the edge.
    drive(1'b1, 1'b0, 1, 1);               // phase 1, mode 0: 2
    #1;
    check("R8 output held before edge", int'(out_data), -2048);
    @(negedge clk);
    check("R8 output after one edge", int'(out_data), 2);

    // Two idle slots in a row.
    drive(1'b0, 1'b0, -2048, -2048);
    @(negedge clk);
    check("R9 idle full-scale", int'(out_data), 0);
    drive(1'b0, 1'b1, 2047, 2047);
    @(negedge clk);
    check("R9 idle second slot", int'(out_data), 0);
    drive(1'b1, 1'b0, 40, 4);              // phase 0 again: 40 - 4
    @(negedge clk);
    check("R2 wrap after idle", int'(out_data), 36);

    done = 1'b1;
    finish_run();
  end

endmodule